// File: doc/BRIEF.md
# Segmented Highly Associative Read Cache

This block is a read-only cache that sits between a processor load path and a slower external memory. It holds 512 lines of eight 32-bit words (16 KB). The lines form eight segments of 64 lines each, so every address maps to exactly one segment and can live in any of that segment's 64 ways. A cacheable read that finds its line returns data at once, with no external traffic. A cacheable read that misses starts an eight-word line fill in ascending word order into a victim way. The requester is released as soon as the wanted word arrives, while the rest of the line streams in.

Two input pins steer allocation. `repl_rr` picks the victim policy: a free-running pseudo-random choice, or a per-segment rotating pointer. `lock_floor` reserves the lowest ways of every segment, which is 1/64 of the cache per step, so that lines held there are never evicted. Non-cacheable reads go to memory as single-word reads and leave the cache untouched.

Top module: `seg_cache`

## Requirements
- R1: An address decodes as tag = bits [31:8], segment = bits [7:5], word within line = bits [4:2]. Addresses that differ only in word bits share one line, and the same tag in two different segments occupies two separate lines.
- R2: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first cacheable read of any address misses.
- R3: A cacheable read that hits raises `cpu_ready` in the same cycle as `cpu_req`, with the stored word on `cpu_rdata` and `mem_req` low.
- R4: A cacheable miss raises `mem_req` with `mem_line` high and `mem_addr` equal to the line base (bits [4:0] zero), accepts exactly eight `mem_valid` beats in ascending word order, and keeps `mem_addr` stable while `mem_req` is high. Afterwards the line hits.
- R5: On a line fill, `cpu_ready` is raised in the cycle the beat carrying the requested word arrives on `mem_valid`, and `cpu_rdata` equals that beat.
- R6: A non-cacheable read raises `mem_req` with `mem_line` low and `mem_addr` equal to the request address, completes on one beat, and allocates nothing: an uncached line still misses later and a cached line stays cached.
- R7: With `repl_rr` = 0 the victim is drawn from a free-running 16-bit LFSR, reduced modulo the number of unlocked ways, so repeated misses spread over the unlocked ways.
- R8: With `repl_rr` = 1 each segment keeps its own pointer, reset to 0. The victim is the pointer, or `lock_floor` if the pointer is below it. The pointer then moves to victim+1, and wraps to `lock_floor` after way 63.
- R9: Ways numbered below `lock_floor` (0 to 63) are never chosen as victims in either policy. With `lock_floor` = 63 every miss in a segment lands in way 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_cacheable | input | 1 | 1 = cacheable, 0 = bypass |
| repl_rr | input | 1 | Victim policy: 0 random, 1 round-robin |
| lock_floor | input | 6 | Number of locked low ways per segment |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Read completes this cycle |
| mem_req | output | 1 | External read in progress |
| mem_line | output | 1 | 1 = eight-word line fill, 0 = single word |
| mem_addr | output | 32 | External byte address (line base for fills) |
| mem_valid | input | 1 | External beat valid this cycle |
| mem_rdata | input | 32 | External beat data |

## Verification
The hardest situation to reach is a full segment in which eviction order meets lockdown: all 64 ways must be valid, and the pointer or LFSR must then choose a victim while a nonzero `lock_floor` guards part of the segment. The stimulus first fills a segment completely in round-robin mode with known tags. It then switches to random mode with a raised floor, or with the floor at 63, and drives long runs of misses with fresh tags before reading the locked tags back as hits. A random round-robin run in two segments, with a floor change midway, is checked against a bench model of the pointer that predicts every hit and miss.

// File: rtl/seg_cache_pkg.sv
package seg_cache_pkg;

  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_BYP} fsm_t;

  // Round-robin: the pointer, raised to the floor if it sits in locked ways.
  function automatic int unsigned rr_pick(int unsigned ptr, int unsigned floor_w);
    return (ptr < floor_w) ? floor_w : ptr;
  endfunction

  // Round-robin advance: step past the victim and wrap back to the floor.
  function automatic int unsigned rr_next(int unsigned vic, int unsigned floor_w,
                                          int unsigned ways);
    return (vic >= ways - 1) ? floor_w : vic + 1;
  endfunction

  // Random pick inside the unlocked ways.
  function automatic int unsigned rnd_pick(int unsigned r, int unsigned floor_w,
                                           int unsigned ways);
    return floor_w + (r % (ways - floor_w));
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

endpackage

// File: rtl/seg_lookup.sv
module seg_lookup #(
  parameter int WAYS  = 64,
  parameter int WAY_W = 6,
  parameter int TAG_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]  seg_tags,
  input  logic [WAYS-1:0]             seg_vld,
  input  logic [TAG_W-1:0]            tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = seg_vld[w] && (seg_tags[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign hit = |match;

  // R3: a line is never held twice in one segment
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import seg_cache_pkg::*;
#(
  parameter int SEGS  = 8,
  parameter int SEG_W = 3,
  parameter int WAYS  = 64,
  parameter int WAY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg,
  input  logic             repl_rr,
  input  logic [WAY_W-1:0] lock_floor,
  input  logic             alloc,
  output logic [WAY_W-1:0] victim
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  rr_ptr [SEGS];

  always_comb begin
    if (repl_rr)
      victim = WAY_W'(rr_pick(32'(rr_ptr[seg]), 32'(lock_floor)));
    else
      victim = WAY_W'(rnd_pick(32'(lfsr_q), 32'(lock_floor), WAYS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= 16'hACE1;
      for (int s = 0; s < SEGS; s++) rr_ptr[s] <= '0;
    end else begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (alloc && repl_rr)
        rr_ptr[seg] <= WAY_W'(rr_next(32'(victim), 32'(lock_floor), WAYS));
    end
  end

  // R9: an allocation never lands in a locked way
  a_r9_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (victim >= lock_floor));

endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_cache_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEG_W = 3,
  parameter int WAY_W = 6,
  parameter int WRD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_cacheable,
  input  logic             repl_rr,
  input  logic [WAY_W-1:0] lock_floor,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_ready,
  output logic             mem_req,
  output logic             mem_line,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_valid,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int SEGS   = 1 << SEG_W;
  localparam int WAYS   = 1 << WAY_W;
  localparam int WORDS  = 1 << WRD_W;
  localparam int OFF    = 2;
  localparam int LINE_B = OFF + WRD_W;
  localparam int TAG_LO = LINE_B + SEG_W;
  localparam int TAG_W  = AW - TAG_LO;
  localparam int LINES  = SEGS * WAYS;

  // storage
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [DW-1:0]    dat_q [LINES*WORDS];

  // control state
  fsm_t             st_q;
  logic [AW-1:0]    line_q;
  logic [WAY_W-1:0] vic_q;
  logic [WRD_W-1:0] beat_q;

  // address fields
  logic [SEG_W-1:0] seg_idx;
  logic [WRD_W-1:0] wrd_idx;
  logic [TAG_W-1:0] req_tag;
  assign seg_idx = cpu_addr[LINE_B +: SEG_W];
  assign wrd_idx = cpu_addr[OFF +: WRD_W];
  assign req_tag = cpu_addr[TAG_LO +: TAG_W];

  // lookup of the addressed segment
  logic [WAYS-1:0][TAG_W-1:0] seg_tags;
  logic [WAYS-1:0]            seg_vld;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_seg
    assign seg_tags[w] = tag_q[{seg_idx, WAY_W'(w)}];
    assign seg_vld[w]  = vld_q[{seg_idx, WAY_W'(w)}];
  end

  seg_lookup #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_look (
    .clk(clk), .rst_n(rst_n), .seg_tags(seg_tags), .seg_vld(seg_vld),
    .tag(req_tag), .hit(hit), .hit_way(hit_way)
  );

  // named events
  logic acc_hit, alloc_ev, byp_ev, fill_beat, last_ev, crit_ev, byp_done;
  assign acc_hit   = (st_q == ST_IDLE) && cpu_req && cpu_cacheable && hit;
  assign alloc_ev  = (st_q == ST_IDLE) && cpu_req && cpu_cacheable && !hit;
  assign byp_ev    = (st_q == ST_IDLE) && cpu_req && !cpu_cacheable;
  assign fill_beat = (st_q == ST_FILL) && mem_valid;
  assign last_ev   = fill_beat && (beat_q == WRD_W'(WORDS - 1));
  assign crit_ev   = fill_beat && (beat_q == line_q[OFF +: WRD_W]);
  assign byp_done  = (st_q == ST_BYP) && mem_valid;

  victim_sel #(.SEGS(SEGS), .SEG_W(SEG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_vic (
    .clk(clk), .rst_n(rst_n), .seg(seg_idx), .repl_rr(repl_rr),
    .lock_floor(lock_floor), .alloc(alloc_ev), .victim(victim)
  );

  // outputs
  assign cpu_ready = acc_hit || crit_ev || byp_done;
  assign cpu_rdata = acc_hit ? dat_q[{seg_idx, hit_way, wrd_idx}] : mem_rdata;
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_line  = (st_q == ST_FILL);
  assign mem_addr  = (st_q == ST_FILL) ? {line_q[AW-1:LINE_B], {LINE_B{1'b0}}}
                                       : line_q;

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      line_q <= '0;
      vic_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (alloc_ev) begin
            st_q   <= ST_FILL;
            line_q <= cpu_addr;
            vic_q  <= victim;
            beat_q <= '0;
          end else if (byp_ev) begin
            st_q   <= ST_BYP;
            line_q <= cpu_addr;
          end
        end
        ST_FILL: begin
          if (mem_valid) begin
            beat_q <= beat_q + 1'b1;
            if (last_ev) st_q <= ST_IDLE;
          end
        end
        ST_BYP:  if (mem_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // valid bits: dropped when a fill starts, set when it ends
  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (alloc_ev) vld_q[{seg_idx, victim}] <= 1'b0;
    else if (last_ev) vld_q[{line_q[LINE_B +: SEG_W], vic_q}] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (last_ev) tag_q[{line_q[LINE_B +: SEG_W], vic_q}] <= line_q[TAG_LO +: TAG_W];
    if (fill_beat) dat_q[{line_q[LINE_B +: SEG_W], vic_q, beat_q}] <= mem_rdata;
  end

  // checker: beats accepted per external transaction
  logic [WRD_W:0] chk_beats;
  always_ff @(posedge clk) begin
    if (!rst_n || !mem_req) chk_beats <= '0;
    else if (mem_valid) chk_beats <= chk_beats + 1'b1;
  end

  a_r4_eight_beats: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_req) && $past(mem_line)) |-> (chk_beats == (WRD_W+1)'(WORDS)));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));

  a_r6_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_req) && !$past(mem_line)) |-> (chk_beats == 1));

  a_r5_ready_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && mem_req) |-> mem_valid);

  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !mem_req) |-> (cpu_req && cpu_cacheable));

endmodule

// File: tb/seg_cache_tb.sv
`timescale 1ns/1ps
module seg_cache_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0;
  logic [31:0] cpu_addr = 0;
  logic        cpu_cacheable = 0;
  logic        repl_rr = 0;
  logic [5:0]  lock_floor = 0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_line;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;

  seg_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_cacheable(cpu_cacheable), .repl_rr(repl_rr), .lock_floor(lock_floor),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_line(mem_line), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // external memory content
  function automatic logic [31:0] mword(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5C3A_9F01;
  endfunction

  // R1: tag [31:8], segment [7:5], word [4:2]
  function automatic logic [31:0] mk_addr(int unsigned tag, int unsigned seg,
                                          int unsigned wrd);
    return {tag[23:0], seg[2:0], wrd[2:0], 2'b00};
  endfunction

  // round-robin reference (R8, R9)
  int unsigned mtag [8][64];
  bit          mvld [8][64];
  int unsigned mptr [8];

  function automatic bit m_hit(int unsigned seg, int unsigned tag);
    for (int w = 0; w < 64; w++)
      if (mvld[seg][w] && mtag[seg][w] == tag) return 1;
    return 0;
  endfunction

  task automatic m_fill(int unsigned seg, int unsigned tag, int unsigned fl);
    int unsigned v;
    v = (mptr[seg] < fl) ? fl : mptr[seg];
    mtag[seg][v] = tag;
    mvld[seg][v] = 1;
    mptr[seg] = (v == 63) ? fl : v + 1;
  endtask

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory responder: ascending beats with random gaps
  int bt = 0;
  initial begin
    mem_valid = 0;
    mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (!mem_req) begin
        mem_valid = 0;
        bt = 0;
      end else begin
        if (mem_valid) bt++;
        if (bt < (mem_line ? 8 : 1) && ($urandom % 3 != 0)) begin
          mem_valid = 1;
          mem_rdata = mword(mem_addr + 32'(bt * 4));
        end else begin
          mem_valid = 0;
        end
      end
    end
  end

  // one read; results left in these variables
  logic [31:0] r_data, r_maddr;
  int          r_cyc;
  bit          r_ext, r_mline, r_beat, r_seen;

  task automatic do_rd(logic [31:0] a, bit cach);
    @(negedge clk);
    while (mem_req) @(negedge clk);
    cpu_req = 1;
    cpu_addr = a;
    cpu_cacheable = cach;
    #1;
    r_cyc = 0; r_ext = 0; r_seen = 0;
    while (!cpu_ready) begin
      if (mem_req && !r_seen) begin
        r_seen = 1; r_maddr = mem_addr; r_mline = mem_line;
      end
      if (mem_req) r_ext = 1;
      @(negedge clk); #1;
      r_cyc++;
    end
    if (mem_req) r_ext = 1;
    if (mem_req && !r_seen) begin
      r_seen = 1; r_maddr = mem_addr; r_mline = mem_line;
    end
    r_beat = mem_valid;
    r_data = cpu_rdata;
    cpu_req = 0;
  endtask

  // read plus checks; exp_ext < 0 means not predicted
  task automatic rd_chk(logic [31:0] a, bit cach, int exp_ext, string rq);
    do_rd(a, cach);
    check(r_data == mword(a), cach ? (r_ext ? "R5 data" : "R3 data") : "R6 data",
          r_data, mword(a));
    if (exp_ext >= 0)
      check(r_ext == exp_ext[0], rq, 32'(r_ext), 32'(exp_ext));
    if (!r_ext)
      check(r_cyc == 0, "R3 same-cycle ready", r_cyc, 0);
    else begin
      check(r_beat, "R5 ready with beat", 32'(r_beat), 1);
      if (cach)
        check(r_mline && r_maddr == {a[31:5], 5'b0}, "R4 line fill address",
              r_maddr, {a[31:5], 5'b0});
      else
        check(!r_mline && r_maddr == a, "R6 single-word address", r_maddr, a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cpu_req = 0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < 64; w++) mvld[s][w] = 0;
    end
    rst_n = 1;
  endtask

  initial begin
    int unsigned seg, tag;
    bit cach, exp_hit;
    int miss_cnt;
    void'($urandom(32'd20240611));

    // R2: reset state
    do_reset();
    #1;
    check(!cpu_ready, "R2 ready low after reset", 32'(cpu_ready), 0);
    check(!mem_req, "R2 mem_req low after reset", 32'(mem_req), 0);
    rd_chk(mk_addr(7, 2, 3), 1, 1, "R2 first read misses");

    // R1: same line for other word, separate line in another segment
    rd_chk(mk_addr(7, 2, 6), 1, 0, "R1 same line hits");
    rd_chk(mk_addr(7, 4, 3), 1, 1, "R1 other segment misses");
    rd_chk(mk_addr(7, 2, 0), 1, 0, "R4 filled line hits");
    rd_chk(mk_addr(7, 2, 7), 1, 0, "R4 last word hits");

    // R6: bypass of a cached line and of an uncached line
    rd_chk(mk_addr(7, 2, 1), 0, 1, "R6 bypass goes external");
    rd_chk(mk_addr(7, 2, 1), 1, 0, "R6 cached line kept");
    rd_chk(mk_addr(9, 1, 5), 0, 1, "R6 bypass goes external");
    rd_chk(mk_addr(9, 1, 5), 1, 1, "R6 bypass did not allocate");

    // R8: random round-robin traffic against the reference, floor change midway
    do_reset();
    @(negedge clk);
    repl_rr = 1;
    lock_floor = 0;
    for (int i = 0; i < 700; i++) begin
      if (i == 350) begin
        @(negedge clk);
        lock_floor = 5;
      end
      seg  = $urandom % 2;
      tag  = 1 + $urandom % 80;
      cach = ($urandom % 10) != 0;
      exp_hit = m_hit(seg, tag);
      if (cach) begin
        rd_chk(mk_addr(tag, seg, $urandom % 8), 1, exp_hit ? 0 : 1,
               "R8 round-robin hit/miss");
        if (!exp_hit) m_fill(seg, tag, lock_floor);
      end else begin
        rd_chk(mk_addr(tag, seg, $urandom % 8), 0, 1, "R6 bypass external");
      end
    end

    // R9 + R7: lock 8 ways, then random misses must spare them
    do_reset();
    @(negedge clk);
    repl_rr = 1;
    lock_floor = 0;
    for (int t = 0; t < 64; t++) rd_chk(mk_addr(t, 3, t % 8), 1, 1, "R8 fill segment");
    for (int t = 0; t < 64; t++) rd_chk(mk_addr(t, 3, 2), 1, 0, "R8 full segment hits");
    @(negedge clk);
    repl_rr = 0;
    lock_floor = 8;
    for (int t = 0; t < 200; t++) rd_chk(mk_addr(100 + t, 3, t % 8), 1, 1, "R7 fresh tag misses");
    for (int t = 0; t < 8; t++) rd_chk(mk_addr(t, 3, 4), 1, 0, "R9 locked line survives");
    miss_cnt = 0;
    for (int t = 8; t < 64; t++) begin
      rd_chk(mk_addr(t, 3, 1), 1, -1, "R7");
      if (r_ext) miss_cnt++;
    end
    check(miss_cnt > 0, "R7 random evicts unlocked ways", miss_cnt, 1);

    // R9: floor at 63, every miss goes to way 63
    do_reset();
    @(negedge clk);
    repl_rr = 1;
    lock_floor = 0;
    for (int t = 0; t < 64; t++) rd_chk(mk_addr(t, 5, 0), 1, 1, "R8 fill segment");
    @(negedge clk);
    repl_rr = 0;
    lock_floor = 63;
    rd_chk(mk_addr(200, 5, 3), 1, 1, "R9 miss at floor 63");
    rd_chk(mk_addr(201, 5, 3), 1, 1, "R9 miss at floor 63");
    rd_chk(mk_addr(62, 5, 3), 1, 0, "R9 way 62 kept");
    rd_chk(mk_addr(0, 5, 3), 1, 0, "R9 way 0 kept");
    rd_chk(mk_addr(63, 5, 3), 1, 1, "R9 way 63 replaced");
    rd_chk(mk_addr(200, 5, 3), 1, 1, "R9 only way 63 rotates");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule